// File: doc/BRIEF.md
# Static Memory Bus Timing Monitor

A passive observer for an asynchronous static memory bus. It samples the address, chip-select, write-strobe, output-enable and data lines on a fast reference clock. It measures in clock counts how long each signal has held its value or level, and at the moment a rule applies it compares the count with a programmable minimum. The monitor never drives the bus. Its whole output is a set of sticky violation bits, one for each timing rule, and a saturating counter of the cycles in which at least one rule broke.

Each minimum is an 8-bit count that is captured while the monitor is disabled and frozen while it is enabled. A write is active while chip-select and the write strobe are both high. The write ends in the first sample in which either of them is low, whichever falls first. The address and data counters restart whenever the value changes. The level counters restart whenever their line is low. All counters stop at their maximum value.

Top module: `smem_timing_mon`

## Requirements
- R1: When the address changes after a span that had a read (chip-select and output-enable high, write strobe low) and no write, a span shorter than `min_rd_cycle` samples sets flag bit 0.
- R2: When the address changes after a span that contained any active write sample, a span shorter than `min_wr_cycle` samples sets flag bit 1.
- R3: In the first active write sample, the number of earlier samples that held the same address must be at least `min_addr_setup`. A change of address in that sample counts as zero. A shortfall sets bit 2.
- R4: At the end of a write, the address must have been stable for at least `min_addr_to_end` samples before the end sample. Otherwise bit 3 is set.
- R5: At the end of a write, the write strobe must have been high for at least `min_we_pulse` consecutive samples. Otherwise bit 4 is set.
- R6: At the end of a write, chip-select must have been high for at least `min_cs_to_end` consecutive samples. Otherwise bit 5 is set.
- R7: At the end of a write, the data must have been unchanged for at least `min_data_setup` samples before the end sample. Otherwise bit 6 is set.
- R8: Starting with the end sample, the data must stay unchanged for `min_data_hold` samples. A change inside that window sets bit 7. A minimum of zero disables this rule.
- R9: The end of a write is the first sample in which chip-select or the write strobe is low, whichever falls first.
- R10: Flags are sticky and appear one clock after the violating sample. `clear` zeroes all flags and the counter, but a violation in the same cycle as `clear` is still recorded.
- R11: `viol_count` rises by exactly one for each violating cycle, however many rules break in that cycle. It saturates at its maximum and does not wrap.
- R12: Minimums are captured only while `enable` is low. While `enable` is low, no violation is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Checking on; minimums frozen while high |
| clear | input | 1 | Clears flags and counter |
| bus_addr | input | ADDR_W | Sampled address lines |
| bus_cs | input | 1 | Chip-select, active high |
| bus_we | input | 1 | Write strobe, active high |
| bus_oe | input | 1 | Output-enable, active high |
| bus_data | input | DATA_W | Sampled data lines |
| min_rd_cycle | input | TW | Minimum read-span address stability |
| min_wr_cycle | input | TW | Minimum write-span address stability |
| min_addr_setup | input | TW | Address setup before write start |
| min_addr_to_end | input | TW | Address valid up to write end |
| min_we_pulse | input | TW | Write strobe pulse width |
| min_cs_to_end | input | TW | Chip-select width up to write end |
| min_data_setup | input | TW | Data setup before write end |
| min_data_hold | input | TW | Data hold from write end |
| viol_flags | output | 8 | Sticky per-rule violation bits |
| viol_count | output | CNT_W | Saturating count of violating cycles |

## Verification
Two events can fall in the same cycle. The first is `clear` together with a fresh violation: the bench raises `clear` in exactly the sample that ends a write with a short strobe. It then expects only that rule's bit to remain, with a count of one. The second is two rules breaking in one sample: a write whose strobe and chip-select are both too short ends in a single sample. The bench expects both bits to be set and the counter to rise by one. A behavioural model compares flags and count on every clock throughout.

// File: rtl/smem_mon_pkg.sv
package smem_mon_pkg;
   localparam int NRULE    = 8;
   localparam int RULE_RC  = 0;
   localparam int RULE_WC  = 1;
   localparam int RULE_AS  = 2;
   localparam int RULE_AW  = 3;
   localparam int RULE_WE  = 4;
   localparam int RULE_CW  = 5;
   localparam int RULE_DS  = 6;
   localparam int RULE_DH  = 7;
endpackage

// File: rtl/smem_run_ctr.sv
// Saturating run-length counter. CHANGE_MODE=1: counts samples with an
// unchanged value (restart at 1). CHANGE_MODE=0: counts consecutive high samples.
module smem_run_ctr #(
   parameter int W           = 8,
   parameter int TW          = 8,
   parameter bit CHANGE_MODE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  sig,
   output logic [W-1:0]  last,
   output logic [TW-1:0] run
);
   localparam logic [TW-1:0] RUN_MAX = '1;

   logic [TW-1:0] run_inc;
   logic [TW-1:0] run_nxt;

   assign run_inc = (run == RUN_MAX) ? RUN_MAX : run + 1'b1;

   generate
      if (CHANGE_MODE) begin : g_change
         assign run_nxt = (sig != last) ? TW'(1) : run_inc;
      end else begin : g_level
         assign run_nxt = (sig != '0) ? run_inc : '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last <= '0;
         run  <= '0;
      end else begin
         last <= sig;
         run  <= run_nxt;
      end
   end
endmodule

// File: rtl/smem_hold_trk.sv
module smem_hold_trk #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          end_evt,
   input  logic          changed,
   input  logic [TW-1:0] min_hold,
   output logic          viol
);
   logic          pend;
   logic [TW-1:0] cnt;
   logic [TW:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt} + 1'b1;
   assign viol    = changed & ((end_evt & (min_hold != '0)) | pend);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         cnt  <= '0;
      end else if (end_evt) begin
         pend <= !changed && (min_hold > TW'(1));
         cnt  <= TW'(1);
      end else if (pend) begin
         if (changed) begin
            pend <= 1'b0;
         end else begin
            cnt  <= cnt_inc[TW-1:0];
            pend <= cnt_inc < {1'b0, min_hold};
         end
      end
   end
endmodule

// File: rtl/smem_viol_log.sv
module smem_viol_log #(
   parameter int NR    = 8,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [NR-1:0]    viol,
   output logic [NR-1:0]    flags,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] base;

   assign base = clear ? '0 : count;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
         count <= '0;
      end else begin
         flags <= (clear ? '0 : flags) | viol;
         if (viol != '0 && base != CNT_MAX) count <= base + 1'b1;
         else                               count <= base;
      end
   end
endmodule

// File: rtl/smem_timing_mon.sv
module smem_timing_mon
   import smem_mon_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int TW     = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              clear,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_cs,
   input  logic              bus_we,
   input  logic              bus_oe,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [TW-1:0]     min_rd_cycle,
   input  logic [TW-1:0]     min_wr_cycle,
   input  logic [TW-1:0]     min_addr_setup,
   input  logic [TW-1:0]     min_addr_to_end,
   input  logic [TW-1:0]     min_we_pulse,
   input  logic [TW-1:0]     min_cs_to_end,
   input  logic [TW-1:0]     min_data_setup,
   input  logic [TW-1:0]     min_data_hold,
   output logic [NRULE-1:0]  viol_flags,
   output logic [CNT_W-1:0]  viol_count
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
         $error("bus widths must be positive");
      end
      if (TW < 2 || CNT_W < 2) begin : g_bad_cnt
         $error("counter widths must be at least 2");
      end
   endgenerate

   logic [TW-1:0]     lim [NRULE];
   logic [TW-1:0]     lim_in [NRULE];
   logic [ADDR_W-1:0] addr_last;
   logic [DATA_W-1:0] data_last;
   logic [TW-1:0]     addr_run, data_run, we_run, cs_run;
   logic              we_last, cs_last;
   logic              act, act_q, rd, a_chg, d_chg, wr_start, wr_end;
   logic              had_wr, had_rd, hold_viol;
   logic [TW-1:0]     setup;
   logic [NRULE-1:0]  rule, viol;

   assign lim_in[RULE_RC] = min_rd_cycle;
   assign lim_in[RULE_WC] = min_wr_cycle;
   assign lim_in[RULE_AS] = min_addr_setup;
   assign lim_in[RULE_AW] = min_addr_to_end;
   assign lim_in[RULE_WE] = min_we_pulse;
   assign lim_in[RULE_CW] = min_cs_to_end;
   assign lim_in[RULE_DS] = min_data_setup;
   assign lim_in[RULE_DH] = min_data_hold;

   // R12: minimums captured only while checking is off
   for (genvar i = 0; i < NRULE; i++) begin : g_lim
      always_ff @(posedge clk) begin
         if (!rst_n)       lim[i] <= '0;
         else if (!enable) lim[i] <= lim_in[i];
      end
   end

   smem_run_ctr #(.W(ADDR_W), .TW(TW), .CHANGE_MODE(1'b1)) u_addr_run (
      .clk(clk), .rst_n(rst_n), .sig(bus_addr), .last(addr_last), .run(addr_run));
   smem_run_ctr #(.W(DATA_W), .TW(TW), .CHANGE_MODE(1'b1)) u_data_run (
      .clk(clk), .rst_n(rst_n), .sig(bus_data), .last(data_last), .run(data_run));
   smem_run_ctr #(.W(1), .TW(TW), .CHANGE_MODE(1'b0)) u_we_run (
      .clk(clk), .rst_n(rst_n), .sig(bus_we), .last(we_last), .run(we_run));
   smem_run_ctr #(.W(1), .TW(TW), .CHANGE_MODE(1'b0)) u_cs_run (
      .clk(clk), .rst_n(rst_n), .sig(bus_cs), .last(cs_last), .run(cs_run));

   assign act      = bus_cs & bus_we;
   assign act_q    = cs_last & we_last;
   assign rd       = bus_cs & bus_oe & ~bus_we;
   assign a_chg    = bus_addr != addr_last;
   assign d_chg    = bus_data != data_last;
   assign wr_start = act & ~act_q;
   assign wr_end   = act_q & ~act;              // R9: first of the two to drop
   assign setup    = a_chg ? '0 : addr_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         had_wr <= 1'b0;
         had_rd <= 1'b0;
      end else if (a_chg) begin
         had_wr <= act;
         had_rd <= rd;
      end else begin
         had_wr <= had_wr | act;
         had_rd <= had_rd | rd;
      end
   end

   smem_hold_trk #(.TW(TW)) u_hold (
      .clk(clk), .rst_n(rst_n), .end_evt(wr_end), .changed(d_chg),
      .min_hold(lim[RULE_DH]), .viol(hold_viol));

   always_comb begin
      rule          = '0;
      rule[RULE_RC] = a_chg & ~had_wr & had_rd & (addr_run < lim[RULE_RC]);
      rule[RULE_WC] = a_chg & had_wr & (addr_run < lim[RULE_WC]);
      rule[RULE_AS] = wr_start & (setup < lim[RULE_AS]);
      rule[RULE_AW] = wr_end & (addr_run < lim[RULE_AW]);
      rule[RULE_WE] = wr_end & (we_run < lim[RULE_WE]);
      rule[RULE_CW] = wr_end & (cs_run < lim[RULE_CW]);
      rule[RULE_DS] = wr_end & (data_run < lim[RULE_DS]);
      rule[RULE_DH] = hold_viol;
   end

   assign viol = enable ? rule : '0;

   smem_viol_log #(.NR(NRULE), .CNT_W(CNT_W)) u_log (
      .clk(clk), .rst_n(rst_n), .clear(clear), .viol(viol),
      .flags(viol_flags), .count(viol_count));
endmodule

// File: rtl/smem_timing_mon_chk.sv
module smem_timing_mon_chk #(
   parameter int NR    = 8,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             clear,
   input logic [NR-1:0]    viol,
   input logic [NR-1:0]    viol_flags,
   input logic [CNT_W-1:0] viol_count
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> ((viol_flags & $past(viol_flags)) == $past(viol_flags)));

   a_r10_clear_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (viol_flags == $past(viol)));

   a_r11_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && viol_count != CMAX) |=>
         (viol_count == $past(viol_count) + CNT_W'($past(viol) != '0)));

   a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && viol_count == CMAX) |=> (viol_count == CMAX));

   a_r12_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !clear) |=> ($stable(viol_flags) && $stable(viol_count)));
endmodule

bind smem_timing_mon smem_timing_mon_chk #(.NR(smem_mon_pkg::NRULE), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear), .viol(viol),
   .viol_flags(viol_flags), .viol_count(viol_count));

// File: tb/test_smem_timing_mon.sv
`timescale 1ns/1ps
module test_smem_timing_mon;
   localparam int CW   = 3;
   localparam int CMAX = 7;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, clr = 1'b0;
   logic [15:0] a = '0, d = '0;
   logic cs = 1'b0, we = 1'b0, oe = 1'b0;
   logic [7:0] lim_in [8];
   logic [7:0] flags;
   logic [CW-1:0] cnt;
   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   smem_timing_mon #(.ADDR_W(16), .DATA_W(16), .TW(8), .CNT_W(CW)) i_smem_timing_mon (
      .clk(clk), .rst_n(rst_n), .enable(en), .clear(clr),
      .bus_addr(a), .bus_cs(cs), .bus_we(we), .bus_oe(oe), .bus_data(d),
      .min_rd_cycle(lim_in[0]), .min_wr_cycle(lim_in[1]), .min_addr_setup(lim_in[2]),
      .min_addr_to_end(lim_in[3]), .min_we_pulse(lim_in[4]), .min_cs_to_end(lim_in[5]),
      .min_data_setup(lim_in[6]), .min_data_hold(lim_in[7]),
      .viol_flags(flags), .viol_count(cnt));

   // behavioural reference model
   int ma, md, maage, mdage, mwe, mcs, mwq, mcq, mhw, mhr, mpend, mhc, mflags, mcnt;
   int ml [8];
   always @(posedge clk) begin
      int v, act, actq, rdv, achg, dchg, setup;
      if (!rst_n) begin
         ma = 0; md = 0; maage = 0; mdage = 0; mwe = 0; mcs = 0; mwq = 0; mcq = 0;
         mhw = 0; mhr = 0; mpend = 0; mhc = 0; mflags = 0; mcnt = 0;
         foreach (ml[i]) ml[i] = 0;
      end else begin
         act = (cs && we); actq = (mcq && mwq); rdv = (cs && oe && !we);
         achg = (int'(a) != ma); dchg = (int'(d) != md);
         setup = achg ? 0 : maage;
         v = 0;
         if (achg && mhw && maage < ml[1]) v |= 1 << 1;
         if (achg && !mhw && mhr && maage < ml[0]) v |= 1 << 0;
         if (act && !actq && setup < ml[2]) v |= 1 << 2;
         if (actq && !act) begin
            if (maage < ml[3]) v |= 1 << 3;
            if (mwe < ml[4]) v |= 1 << 4;
            if (mcs < ml[5]) v |= 1 << 5;
            if (mdage < ml[6]) v |= 1 << 6;
         end
         if (dchg && ((actq && !act && ml[7] != 0) || mpend)) v |= 1 << 7;
         if (!en) v = 0;
         mflags = (clr ? 0 : mflags) | v;
         mcnt = (clr ? 0 : mcnt) + ((v != 0) ? 1 : 0);
         if (mcnt > CMAX) mcnt = CMAX;
         if (actq && !act) begin mpend = (!dchg && ml[7] > 1); mhc = 1; end
         else if (mpend) begin
            if (dchg) mpend = 0;
            else begin mhc++; mpend = (mhc < ml[7]); end
         end
         if (achg) begin mhw = act; mhr = rdv; end
         else begin mhw = mhw | act; mhr = mhr | rdv; end
         maage = achg ? 1 : ((maage < 255) ? maage + 1 : 255);
         mdage = dchg ? 1 : ((mdage < 255) ? mdage + 1 : 255);
         mwe = we ? ((mwe < 255) ? mwe + 1 : 255) : 0;
         mcs = cs ? ((mcs < 255) ? mcs + 1 : 255) : 0;
         ma = int'(a); md = int'(d); mwq = we; mcq = cs;
         if (!en) foreach (ml[i]) ml[i] = int'(lim_in[i]);
      end
   end

   task automatic chk(input string tag, input int act_v, input int exp_v);
      n_chk++;
      if (act_v != exp_v) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
      end
   endtask

   // one sample: drive at negedge, compare with model after the edge
   task automatic step(input int na, input int nd, input bit ncs, input bit nwe,
                       input bit noe, input bit nclr);
      a = 16'(na); d = 16'(nd); cs = ncs; we = nwe; oe = noe; clr = nclr;
      @(posedge clk);
      @(negedge clk);
      if (rst_n) begin
         chk("R10 model flags", int'(flags), mflags);
         chk("R11 model count", int'(cnt), mcnt);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(int'(a), int'(d), 0, 0, 0, 0);
   endtask

   task automatic clear_step();
      step(int'(a), int'(d), 0, 0, 0, 1);
   endtask

   // write with strobe high wl samples inside a chip-select of cl samples
   task automatic wr(input int cl, input int wl, input bit clr_at_end);
      int ad = int'(a), dd = int'(d);
      for (int i = 0; i < cl; i++) step(ad, dd, 1, (i >= cl - wl), 0, 0);
      step(ad, dd, 0, 0, 0, clr_at_end);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      lim_in[0] = 6; lim_in[1] = 8; lim_in[2] = 2; lim_in[3] = 5;
      lim_in[4] = 3; lim_in[5] = 4; lim_in[6] = 2; lim_in[7] = 2;
      a = 16'd10; d = 16'h55;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10 reset flags", int'(flags), 0);
      chk("R11 reset count", int'(cnt), 0);
      rst_n = 1'b1;
      idle(12);
      en = 1'b1;
      idle(2);

      // A: compliant write
      clear_step(); idle(1); wr(4, 3, 0); idle(2); step(20, 'h55, 0, 0, 0, 0);
      idle(10);
      chk("R2 clean write flags", int'(flags), 0);
      // B: short strobe
      clear_step(); idle(1); wr(4, 2, 0); idle(2);
      chk("R5 short strobe", int'(flags), 1 << 4);
      chk("R11 one cycle", int'(cnt), 1);
      // C: address moves with chip-select, setup and address-to-end short
      clear_step(); step(30, 'h55, 1, 0, 0, 0);
      for (int i = 0; i < 3; i++) step(30, 'h55, 1, 1, 0, 0);
      step(30, 'h55, 0, 0, 0, 0); idle(10);
      chk("R3 R4 setup and addr-to-end", int'(flags), (1 << 2) | (1 << 3));
      chk("R11 two cycles", int'(cnt), 2);
      // D: late data
      clear_step(); idle(1);
      step(30, 'h55, 1, 0, 0, 0); step(30, 'h55, 1, 1, 0, 0); step(30, 'h55, 1, 1, 0, 0);
      step(30, 'h66, 1, 1, 0, 0); step(30, 'h66, 0, 0, 0, 0); idle(3);
      chk("R7 data setup", int'(flags), 1 << 6);
      // E: early data change after end
      clear_step(); idle(1); wr(4, 3, 0); step(30, 'h77, 0, 0, 0, 0); idle(3);
      chk("R8 data hold", int'(flags), 1 << 7);
      // F: short write span
      clear_step(); step(40, 'h77, 0, 0, 0, 0); wr(4, 3, 0); step(50, 'h77, 0, 0, 0, 0);
      idle(3);
      chk("R2 short write span", int'(flags), 1 << 1);
      // G: short read span
      clear_step();
      for (int i = 0; i < 3; i++) step(60, 'h77, 1, 0, 1, 0);
      step(70, 'h77, 0, 0, 0, 0); idle(3);
      chk("R1 short read span", int'(flags), 1 << 0);
      // H: chip-select drops before strobe
      clear_step(); idle(2);
      for (int i = 0; i < 3; i++) step(70, 'h77, 1, 1, 0, 0);
      step(70, 'h77, 0, 1, 0, 0); step(70, 'h77, 0, 1, 0, 0); idle(3);
      chk("R6 R9 end at chip-select drop", int'(flags), 1 << 5);
      // I: clear together with a new violation
      wr(4, 2, 1); idle(2);
      chk("R10 clear with new violation", int'(flags), 1 << 4);
      chk("R10 count after clear", int'(cnt), 1);
      // J: two rules in one sample
      clear_step(); idle(1); wr(2, 2, 0); idle(2);
      chk("R11 two rules one cycle flags", int'(flags), (1 << 4) | (1 << 5));
      chk("R11 two rules one cycle count", int'(cnt), 1);
      // K: minimum frozen while enabled
      clear_step(); lim_in[4] = 1; idle(1); wr(4, 2, 0); idle(2);
      chk("R12 minimum frozen", int'(flags), 1 << 4);
      lim_in[4] = 3;
      // L: disabled records nothing
      en = 1'b0; clear_step(); idle(1); wr(2, 1, 0); idle(2);
      chk("R12 disabled flags", int'(flags), 0);
      chk("R12 disabled count", int'(cnt), 0);
      en = 1'b1; idle(1);
      // M: counter saturation
      clear_step();
      for (int k = 0; k < 9; k++) begin idle(1); wr(4, 2, 0); end
      idle(2);
      chk("R11 saturated count", int'(cnt), CMAX);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule